// File: doc/BRIEF.md
# SPI Serial EEPROM Command Front End

This block is the slave-side serial engine in front of a 512-byte nonvolatile array. It oversamples chip select, SCK and SI in the system clock domain. It assembles the opcode and address bytes and streams array or status bytes back on SO. It owns no storage and no write timing. Array reads go through a one-cycle synchronous read port. Every write-related command is handed to a separate write controller as a one-cycle pulse, with its address and data where the command has them.

The write controller decides whether a write really starts. To do so it uses the count of SCK rising edges since chip select fell, which the block reports together with a pulse when chip select rises. Nothing is accepted after reset until chip select has gone from high to low once.

Top module: `spi_eeprom_frontend`

## Requirements
- R1: After reset no command takes effect, SO stays disabled and no chip-select-rise report is made, until a high-to-low transition of cs_ni has been seen; cs_ni held low through reset does not count.
- R2: SI is sampled on rising SCK and SO changes only after falling SCK (mode 0). Every byte moves MSB first.
- R3: Opcode 0x06 pulses wren_o and opcode 0x04 pulses wrdi_o, on the eighth rising SCK. At most one command pulse is active in any cycle.
- R4: Opcode 0000_A011 followed by an address byte reads from address {A, byte}. The data streams out on SO starting with the next falling SCK, and the address advances by one after each byte.
- R5: A sequential read continues from 0x1FF to 0x000.
- R6: Opcode 0x05 streams status_i on SO without an address byte. status_i is captured when the opcode ends and again at every byte boundary. Its bit layout is [5:4] watchdog select, [3:2] protection level, [1] write-enable latch, [0] write busy.
- R7: Opcode 0x01 followed by one byte pulses wrsr_o with that byte on cmd_data_o. Later bytes are ignored.
- R8: Opcode 0000_A010, an address byte and N data bytes give N wr_byte_o pulses. Each pulse carries its address on wr_addr_o and its byte on cmd_data_o. The low PAGE_W address bits wrap inside the page and the upper bits stay fixed.
- R9: Any other opcode is ignored until cs_ni rises: no pulses, no read, SO disabled.
- R10: so_oe_o is low whenever cs_ni is high, and high only while read or status data is being shifted out.
- R11: sck_count_o counts rising SCK edges since the last cs_ni fall and saturates at its maximum. cs_rise_o pulses once when cs_ni rises while armed, and the count stays frozen while cs_ni is high.
- R12: SCK may pause for any number of clock cycles with cs_ni low, and the transfer resumes without loss.

SCK high and low phases must each last at least four clk_i cycles, so that a fetched array byte is in place before the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low, synchronous to clk_i |
| sck_i | input | 1 | Serial clock, synchronous to clk_i |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; low means high impedance |
| mem_rd_o | output | 1 | Array read strobe |
| mem_addr_o | output | 9 | Array read address |
| mem_rdata_i | input | 8 | Array read data, valid the cycle after mem_rd_o |
| status_i | input | 8 | Status byte from the write controller |
| wren_o | output | 1 | Set-write-enable command pulse |
| wrdi_o | output | 1 | Clear-write-enable command pulse |
| wrsr_o | output | 1 | Status write pulse, byte on cmd_data_o |
| wr_byte_o | output | 1 | Array byte write pulse |
| wr_addr_o | output | 9 | Address for wr_byte_o |
| cmd_data_o | output | 8 | Data byte for wrsr_o or wr_byte_o |
| cs_rise_o | output | 1 | Pulse when chip select rises |
| sck_count_o | output | CNT_W | Rising SCK edges since chip select fell, saturating |

## Verification
A wrong phase or bit count shows within one byte time. The symptom is a command pulse that is missing or extra, or one that lands on the wrong byte, for example a write pulse carrying the address byte as data. A bad address register or a bad page wrap shows at the first wr_byte_o or streamed byte after the boundary, as the wrong address or the wrong data. A wrong lockout or enable shows at once as an SO enable, a command or a count report while the block should be deaf.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam int ADDR_BITS = 9;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    PH_OP, PH_RADDR, PH_WADDR, PH_WDATA, PH_WRSR, PH_RD, PH_SR, PH_IGN
  } phase_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE
  } cmd_e;
endpackage

// File: rtl/spi_ee_edges.sv
module spi_ee_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic armed_o
);
  logic sck_q, cs_q;

  // cs_q resets low so a select held low through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_fall_o) armed_o <= 1'b1;
    end
  end

  assign sck_rise_o = sck_i & ~sck_q;
  assign sck_fall_o = ~sck_i & sck_q;
  assign cs_fall_o  = ~cs_ni & cs_q;
  assign cs_rise_o  = cs_ni & ~cs_q;
endmodule

// File: rtl/spi_ee_decode.sv
module spi_ee_decode import spi_ee_pkg::*; (
  input  logic [BYTE_BITS-1:0] op_i,
  output cmd_e                 cmd_o,
  output logic                 a8_o
);
  // bit 3 carries address bit 8 for array read/write, must be 0 otherwise
  always_comb begin
    cmd_o = CMD_NONE;
    a8_o  = op_i[3];
    if (op_i[7:4] == 4'h0) begin
      unique case (op_i[2:0])
        3'b110:  if (!op_i[3]) cmd_o = CMD_WREN;
        3'b100:  if (!op_i[3]) cmd_o = CMD_WRDI;
        3'b101:  if (!op_i[3]) cmd_o = CMD_RDSR;
        3'b001:  if (!op_i[3]) cmd_o = CMD_WRSR;
        3'b011:  cmd_o = CMD_READ;
        3'b010:  cmd_o = CMD_WRITE;
        default: cmd_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/spi_ee_sck_count.sv
module spi_ee_sck_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         count_o <= '0;
    else if (clr_i)                      count_o <= '0;
    else if (inc_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
  end

  assert_cnt_saturate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && count_o == CNT_MAX) |=> (count_o == CNT_MAX));
endmodule

// File: rtl/spi_eeprom_frontend.sv
module spi_eeprom_frontend import spi_ee_pkg::*; #(
  parameter int PAGE_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 sck_i,
  input  logic                 si_i,
  output logic                 so_o,
  output logic                 so_oe_o,
  output logic                 mem_rd_o,
  output logic [ADDR_BITS-1:0] mem_addr_o,
  input  logic [BYTE_BITS-1:0] mem_rdata_i,
  input  logic [BYTE_BITS-1:0] status_i,
  output logic                 wren_o,
  output logic                 wrdi_o,
  output logic                 wrsr_o,
  output logic                 wr_byte_o,
  output logic [ADDR_BITS-1:0] wr_addr_o,
  output logic [BYTE_BITS-1:0] cmd_data_o,
  output logic                 cs_rise_o,
  output logic [CNT_W-1:0]     sck_count_o
);
  localparam int ADDR_W = ADDR_BITS;
  localparam int BYTE_W = BYTE_BITS;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic sck_rise, sck_fall, cs_fall, cs_rise_raw, armed, active;
  logic [BYTE_W-1:0] sr_q, sr_nxt, out_byte_q;
  logic [BIT_W-1:0]  bit_cnt_q, out_idx_q;
  logic [ADDR_W-1:0] rd_addr_q, wr_ptr_q, wr_ptr_inc;
  logic              a8_q, so_q, rd_wait_q, byte_done, op_a8, out_phase;
  phase_e            phase_q;
  cmd_e              cmd;

  spi_ee_edges u_edges (
    .clk_i, .rst_ni, .cs_ni, .sck_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise_raw), .armed_o(armed)
  );

  spi_ee_decode u_dec (.op_i(sr_nxt), .cmd_o(cmd), .a8_o(op_a8));

  spi_ee_sck_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(cs_fall), .inc_i(sck_rise & active), .count_o(sck_count_o)
  );

  assign active     = armed & ~cs_ni;
  assign sr_nxt     = {sr_q[BYTE_W-2:0], si_i};
  assign byte_done  = sck_rise & (bit_cnt_q == LAST_BIT);
  assign wr_ptr_inc = {wr_ptr_q[ADDR_W-1:PAGE_W], wr_ptr_q[PAGE_W-1:0] + 1'b1};
  assign out_phase  = (phase_q == PH_RD) || (phase_q == PH_SR);
  assign so_oe_o    = active & out_phase;
  assign so_o       = so_q;
  assign mem_addr_o = rd_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OP;
      sr_q <= '0; bit_cnt_q <= '0; out_idx_q <= '0; out_byte_q <= '0;
      rd_addr_q <= '0; wr_ptr_q <= '0; a8_q <= 1'b0; so_q <= 1'b0; rd_wait_q <= 1'b0;
      mem_rd_o <= 1'b0; wren_o <= 1'b0; wrdi_o <= 1'b0; wrsr_o <= 1'b0; wr_byte_o <= 1'b0;
      wr_addr_o <= '0; cmd_data_o <= '0; cs_rise_o <= 1'b0;
    end else begin
      wren_o <= 1'b0; wrdi_o <= 1'b0; wrsr_o <= 1'b0; wr_byte_o <= 1'b0; mem_rd_o <= 1'b0;
      cs_rise_o <= cs_rise_raw & armed;
      rd_wait_q <= mem_rd_o;
      if (rd_wait_q) out_byte_q <= mem_rdata_i;
      if (!active) begin
        phase_q <= PH_OP; sr_q <= '0; bit_cnt_q <= '0; out_idx_q <= '0; so_q <= 1'b0;
      end else begin
        if (sck_rise) begin
          sr_q      <= sr_nxt;
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        if (byte_done) begin
          unique case (phase_q)
            PH_OP: begin
              a8_q <= op_a8;
              unique case (cmd)
                CMD_WREN:  begin wren_o <= 1'b1; phase_q <= PH_IGN; end
                CMD_WRDI:  begin wrdi_o <= 1'b1; phase_q <= PH_IGN; end
                CMD_RDSR:  begin out_byte_q <= status_i; phase_q <= PH_SR; end
                CMD_WRSR:  phase_q <= PH_WRSR;
                CMD_READ:  phase_q <= PH_RADDR;
                CMD_WRITE: phase_q <= PH_WADDR;
                default:   phase_q <= PH_IGN;
              endcase
            end
            PH_RADDR: begin
              rd_addr_q <= {a8_q, sr_nxt};
              mem_rd_o  <= 1'b1;
              phase_q   <= PH_RD;
            end
            PH_WADDR: begin
              wr_ptr_q <= {a8_q, sr_nxt};
              phase_q  <= PH_WDATA;
            end
            PH_WDATA: begin
              wr_byte_o  <= 1'b1;
              wr_addr_o  <= wr_ptr_q;
              cmd_data_o <= sr_nxt;
              wr_ptr_q   <= wr_ptr_inc;
            end
            PH_WRSR: begin
              wrsr_o     <= 1'b1;
              cmd_data_o <= sr_nxt;
              phase_q    <= PH_IGN;
            end
            default: ;
          endcase
        end
        if (sck_fall && out_phase) begin
          so_q      <= out_byte_q[LAST_BIT - out_idx_q];
          out_idx_q <= out_idx_q + 1'b1;
          if (out_idx_q == LAST_BIT) begin
            if (phase_q == PH_RD) begin
              rd_addr_q <= rd_addr_q + 1'b1;
              mem_rd_o  <= 1'b1;
            end else begin
              out_byte_q <= status_i;
            end
          end
        end
      end
    end
  end

  assert_cmd_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wren_o, wrdi_o, wrsr_o, wr_byte_o, mem_rd_o}));

  assert_locked_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> !(wren_o || wrdi_o || wrsr_o || wr_byte_o || mem_rd_o || so_oe_o || cs_rise_o));

  assert_so_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active) && !$past(sck_fall)) |-> $stable(so_o));

  assert_rd_spaced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  assert_cnt_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> $stable(sck_count_o));
endmodule

// File: tb/spi_eeprom_frontend_tb.sv
module spi_eeprom_frontend_tb;
  localparam int CW = 6;
  localparam int HP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0;
  logic so, so_oe, mem_rd, wren, wrdi, wrsr, wr_byte, cs_rise;
  logic [8:0] mem_addr, wr_addr;
  logic [7:0] mem_rdata = '0, status = 8'h2D, cmd_data;
  logic [CW-1:0] cnt;

  typedef struct { int kind; int val; string req; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_eeprom_frontend #(.PAGE_W(2), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .status_i(status), .wren_o(wren), .wrdi_o(wrdi),
    .wrsr_o(wrsr), .wr_byte_o(wr_byte), .wr_addr_o(wr_addr), .cmd_data_o(cmd_data),
    .cs_rise_o(cs_rise), .sck_count_o(cnt)
  );

  function automatic logic [7:0] pat(input logic [8:0] a);
    return a[7:0] ^ (a[8] ? 8'hA5 : 8'h3C);
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input int kind, input int val, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: kinds 1 wren, 2 wrdi, 3 wrsr, 4 write byte, 5 cs rise
  task automatic got(input int kind, input int val);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "unexpected event (R1/R9)", kind * 65536 + val, 0);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind && e.val == val, e.req, kind * 65536 + val, e.kind * 65536 + e.val);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wren)    got(1, 0);
      if (wrdi)    got(2, 0);
      if (wrsr)    got(3, int'(cmd_data));
      if (wr_byte) got(4, int'({wr_addr, cmd_data}));
      if (cs_rise) got(5, int'(cnt));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all, output bit oe_any);
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      tick(HP);
      rx[i] = so;
      if (!so_oe) oe_all = 1'b0; else oe_any = 1'b1;
      sck = 1'b1;
      tick(HP);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx; bit a, b;
    xfer(tx, rx, a, b);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic cs_end(input int count, input bit armed);
    if (armed) push(5, count, "R11 count at cs rise");
    cs_n = 1'b1;
    tick(4);
    check(so_oe == 1'b0, "R10 SO off with cs high", int'(so_oe), 0);
  endtask

  task automatic read_byte(input logic [7:0] expv, input string req);
    logic [7:0] rx; bit oe_all, oe_any;
    xfer(8'h00, rx, oe_all, oe_any);
    check(rx == expv, req, int'(rx), int'(expv));
    check(oe_all, "R10 SO enabled during output", int'(oe_all), 1);
  endtask

  initial begin
    logic [7:0] rx; bit oe_all, oe_any;
    // reset with cs held low
    tick(5);
    check(so_oe == 1'b0 && wren == 1'b0 && cs_rise == 1'b0, "R1 reset state",
          int'({so_oe, wren, cs_rise}), 0);
    rst_n = 1'b1;
    tick(3);
    // locked: no fall seen yet
    xfer(8'h06, rx, oe_all, oe_any);
    tick(4);
    check(so_oe == 1'b0, "R1 locked SO off", int'(so_oe), 0);
    cs_end(0, 1'b0);
    xfer(8'h05, rx, oe_all, oe_any);
    check(!oe_any, "R1 locked while cs high", int'(oe_any), 0);

    // R3 set and clear write enable
    cs_begin(); push(1, 0, "R3 wren"); send(8'h06); cs_end(8, 1'b1);
    cs_begin(); push(2, 0, "R3 wrdi"); send(8'h04); cs_end(8, 1'b1);

    // R6 status stream, resampled per byte
    status = 8'h2D;
    cs_begin(); send(8'h05);
    status = 8'h12;
    read_byte(8'h2D, "R6 status byte 1");
    read_byte(8'h12, "R6 status byte 2 resampled");
    cs_end(24, 1'b1);

    // R4 R5 read upper half with wrap
    cs_begin(); send(8'h0B); send(8'hFE);
    read_byte(pat(9'h1FE), "R4 read 0x1FE MSB first (R2)");
    read_byte(pat(9'h1FF), "R4 read increments to 0x1FF");
    read_byte(pat(9'h000), "R5 read wraps to 0x000");
    cs_end(40, 1'b1);

    // R12 read lower half with SCK stalled mid-stream
    cs_begin(); send(8'h03); send(8'h10);
    read_byte(pat(9'h010), "R4 read 0x010");
    tick(300);
    read_byte(pat(9'h011), "R12 read resumes after pause");
    cs_end(32, 1'b1);

    // R7 status write, later bytes ignored
    cs_begin(); push(3, 8'h3C, "R7 wrsr data"); send(8'h01); send(8'h3C); send(8'h77);
    cs_end(24, 1'b1);

    // R8 page write with wrap at 4 bytes
    cs_begin(); send(8'h0A); send(8'h02);
    push(4, {9'h102, 8'h11}, "R8 byte 0"); send(8'h11);
    push(4, {9'h103, 8'h22}, "R8 byte 1"); send(8'h22);
    push(4, {9'h100, 8'h33}, "R8 page wrap"); send(8'h33);
    push(4, {9'h101, 8'h44}, "R8 byte 3"); send(8'h44);
    push(4, {9'h102, 8'h55}, "R8 overwrite"); send(8'h55);
    cs_end(56, 1'b1);

    // R9 undefined opcode swallows following bytes
    cs_begin(); xfer(8'h07, rx, oe_all, oe_any);
    xfer(8'h06, rx, oe_all, oe_any);
    check(!oe_any, "R9 SO off after bad opcode", int'(oe_any), 0);
    cs_end(16, 1'b1);
    cs_begin(); send(8'h8E); send(8'h06); cs_end(16, 1'b1);

    // R11 saturation
    cs_begin();
    for (int k = 0; k < 10; k++) send(8'hFF);
    tick(4);
    check(cnt == CW'('1), "R11 count saturates", int'(cnt), (1 << CW) - 1);
    cs_end((1 << CW) - 1, 1'b1);

    tick(20);
    check(exp_q.size() == 0, "R3/R7/R8/R11 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule